// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Router

This block gives a processor bus access to the internal registers of an interrupt router. Only two registers sit at bus addresses: an index register and a data window. Software first writes the index register to name an internal register. Later window reads and writes then reach that register.

The internal space holds an identification word, a read-only version word and a table of redirection entries. Each entry is seen as a pair of 32-bit words. A write to the identification word also loads a separate arbitration ID, which the router's arbitration logic uses. The whole table is also driven out in parallel for the message logic, which lies outside this block.

The bus is a plain synchronous port with an address, a write strobe and a read strobe. Read data is registered.

Top module: `irq_regwin`

## Requirements
- R1: Bus address 0 is the index register and bus address 1 is the data window. A write to any other bus address changes nothing. A read there returns zero, with the valid flag raised as usual.
- R2: The index register is 8 bits wide and resets to zero. A write to bus address 0 loads `bus_wdata[7:0]`. A read of bus address 0 returns the index in bits 7:0 and zero in every other bit.
- R3: A window access reaches only the internal register that the index currently names. Every other internal register is left unchanged.
- R4: Index 1 is the version word. It reads as the version parameter (default 0x11) in bits 7:0, the highest entry number (NUM_ENT-1, so 15 by default) in bits 23:16, and zero elsewhere. Writes to it have no effect.
- R5: Index 0 is the identification word, with a 4-bit ID in bits 27:24 and zero in every other bit. A window write to it loads the ID from `bus_wdata[27:24]`. The same write loads `arb_id_o` with that value, which is visible from the clock after the write.
- R6: Entry n has its low word at index 0x10+2n and its high word at index 0x11+2n. Low-word fields are: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, trigger mode in bit 15 (1 = level), and mask in bit 16. The high word carries the destination in bits 31:24. All other bits read as zero and ignore writes.
- R7: After reset, every entry reads with its mask bit set and all other fields zero. The ID and the arbitration ID are both zero.
- R8: An index that names no register reads as zero through the window. A write there changes no register.
- R9: Read data and `bus_rvalid` appear on the clock after the read strobe. `bus_rvalid` is high for exactly one cycle per read strobe cycle.
- R10: `redir_tbl_o[64n+63:64n]` holds entry n as {high word, low word}, in the R6 layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | BUS_AW (2) | Word address on the bus |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one clock after `bus_rd` |
| arb_id_o | output | 4 | Arbitration ID, loaded together with the ID |
| redir_tbl_o | output | 64*NUM_ENT | Full redirection table, in parallel |

## Verification
The assertions check several rules on every cycle:
- the valid flag follows the read strobe by one clock;
- the index holds unless it is written;
- the arbitration ID takes the written ID;
- the version word and unimplemented indices read as fixed values;
- the table never changes without a window write.

Only the bench scenarios can show the rest:
- which table word a given index reaches;
- the bit placement of each entry field;
- the masked reset state of the entries;
- that writes to ignored bits, to unused bus addresses and to empty indices leave the other registers intact.

// File: rtl/irq_regwin_pkg.sv
// Package: shared entry type and word packing for the register window.
// Assumes 32-bit window words; field placement is fixed by the packing functions.
package irq_regwin_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_W    = 8;
    localparam logic [IDX_W-1:0] IDX_ID  = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VER = 8'h01;
    localparam logic [IDX_W-1:0] IDX_TBL = 8'h10;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       dmode;
        logic [2:0] deliv;
        logic [7:0] vec;
    } redir_t;

    localparam redir_t REDIR_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                     dmode: 1'b0, deliv: 3'b000, vec: 8'h00};

    // Low word view of an entry.
    function automatic logic [WORD_W-1:0] pack_lo(input redir_t e);
        return {15'b0, e.mask, e.trig, 3'b0, e.dmode, e.deliv, e.vec};
    endfunction

    // High word view of an entry.
    function automatic logic [WORD_W-1:0] pack_hi(input redir_t e);
        return {e.dest, 24'b0};
    endfunction

endpackage

// File: rtl/irq_regwin_index.sv
// Index register and its decode.
// Assumes a single bus access per cycle and a synchronous active-low reset.
// The decode flags and entry number come straight from the stored index.
module irq_regwin_index #(
    parameter int NUM_ENT = 16,
    localparam int ENT_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       idx_o,
    output logic             is_id_o,
    output logic             is_ver_o,
    output logic             in_tbl_o,
    output logic [ENT_W-1:0] ent_o,
    output logic             hi_o
);
    import irq_regwin_pkg::*;

    localparam logic [8:0] TBL_LO = {1'b0, IDX_TBL};
    localparam logic [8:0] TBL_HI = TBL_LO + 9'(2 * NUM_ENT);

    logic [7:0] idx_q;
    logic [7:0] off;

    // Hold the index; load it on a bus write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (wr_en) idx_q <= wdata;
    end

    // Decode the index into a register class and a table position.
    always_comb begin
        off      = idx_q - IDX_TBL;
        is_id_o  = (idx_q == IDX_ID);
        is_ver_o = (idx_q == IDX_VER);
        in_tbl_o = ({1'b0, idx_q} >= TBL_LO) && ({1'b0, idx_q} < TBL_HI);
        ent_o    = off[ENT_W:1];
        hi_o     = off[0];
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/irq_regwin_ident.sv
// Identification and version words.
// The ID and the arbitration ID load from the same write.
// The version word is a constant formed from the parameters.
module irq_regwin_ident #(
    parameter int         NUM_ENT = 16,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        id_wr,
    input  logic [31:0] wdata,
    output logic [31:0] id_word_o,
    output logic [31:0] ver_word_o,
    output logic [3:0]  id_o,
    output logic [3:0]  arb_id_o
);
    logic [3:0] id_q;
    logic [3:0] arb_q;

    // Load the ID and its arbitration copy together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            arb_q <= '0;
        end else if (id_wr) begin
            id_q  <= wdata[27:24];
            arb_q <= wdata[27:24];
        end
    end

    assign id_word_o  = {4'b0, id_q, 24'b0};
    assign ver_word_o = {8'b0, 8'(NUM_ENT - 1), 8'b0, VERSION};
    assign id_o       = id_q;
    assign arb_id_o   = arb_q;

endmodule

// File: rtl/irq_regwin_table.sv
// Redirection table.
// Each entry is written through its low or high word. Bits a word does not
// implement are dropped. The table is also driven out in parallel.
// Assumes the entry number is in range whenever wr_en is high.
module irq_regwin_table #(
    parameter int  NUM_ENT = 16,
    localparam int ENT_W   = $clog2(NUM_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ENT_W-1:0]       ent,
    input  logic                   hi,
    input  logic [31:0]            wdata,
    output logic [31:0]            rd_word_o,
    output logic [64*NUM_ENT-1:0]  flat_o
);
    import irq_regwin_pkg::*;

    redir_t tbl [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        // Update entry i from the word selected by hi.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[i] <= REDIR_RST;
            end else if (wr_en && (ent == ENT_W'(i))) begin
                if (hi) begin
                    tbl[i].dest  <= wdata[31:24];
                end else begin
                    tbl[i].vec   <= wdata[7:0];
                    tbl[i].deliv <= wdata[10:8];
                    tbl[i].dmode <= wdata[11];
                    tbl[i].trig  <= wdata[15];
                    tbl[i].mask  <= wdata[16];
                end
            end
        end
        assign flat_o[64*i +: 64] = {pack_hi(tbl[i]), pack_lo(tbl[i])};
    end

    // Give the word currently named for reads.
    always_comb begin
        rd_word_o = hi ? pack_hi(tbl[ent]) : pack_lo(tbl[ent]);
    end

endmodule

// File: rtl/irq_regwin.sv
// Top of the indirect register window.
// Decodes the two bus addresses and routes window accesses by the index.
// Read data is registered. Assumes at most one of bus_wr or bus_rd
// targets a given register per cycle; a read sees the state before a same-cycle write.
module irq_regwin #(
    parameter int         BUS_AW  = 2,
    parameter int         NUM_ENT = 16,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    output logic [3:0]            arb_id_o,
    output logic [64*NUM_ENT-1:0] redir_tbl_o
);
    localparam int ENT_W = $clog2(NUM_ENT);
    localparam logic [BUS_AW-1:0] A_IDX = BUS_AW'(0);
    localparam logic [BUS_AW-1:0] A_WIN = BUS_AW'(1);

    logic [7:0]       sel_cur;
    logic             is_id, is_ver, in_tbl, hi;
    logic [ENT_W-1:0] ent;
    logic [31:0]      id_word, ver_word, tbl_word, rd_mux;
    logic [3:0]       id_cur;
    logic             win_wr;
    logic [31:0]      rdata_q;
    logic             rvalid_q;

    assign win_wr = bus_wr && (bus_addr == A_WIN);

    irq_regwin_index #(.NUM_ENT(NUM_ENT)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && (bus_addr == A_IDX)),
        .wdata    (bus_wdata[7:0]),
        .idx_o    (sel_cur),
        .is_id_o  (is_id),
        .is_ver_o (is_ver),
        .in_tbl_o (in_tbl),
        .ent_o    (ent),
        .hi_o     (hi)
    );

    irq_regwin_ident #(.NUM_ENT(NUM_ENT), .VERSION(VERSION)) u_ident (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_wr      (win_wr && is_id),
        .wdata      (bus_wdata),
        .id_word_o  (id_word),
        .ver_word_o (ver_word),
        .id_o       (id_cur),
        .arb_id_o   (arb_id_o)
    );

    irq_regwin_table #(.NUM_ENT(NUM_ENT)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (win_wr && in_tbl),
        .ent       (ent),
        .hi        (hi),
        .wdata     (bus_wdata),
        .rd_word_o (tbl_word),
        .flat_o    (redir_tbl_o)
    );

    // Select the read source from the bus address and the index.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_IDX) begin
            rd_mux = {24'b0, sel_cur};
        end else if (bus_addr == A_WIN) begin
            if (is_id)       rd_mux = id_word;
            else if (is_ver) rd_mux = ver_word;
            else if (in_tbl) rd_mux = tbl_word;
        end
    end

    // Register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/irq_regwin_chk.sv
// Checker bound to irq_regwin.
// Watches the bus, the index and the ID for timing and fixed-value rules.
module irq_regwin_chk #(
    parameter int         BUS_AW  = 2,
    parameter int         NUM_ENT = 16,
    parameter logic [7:0] VERSION = 8'h11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BUS_AW-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic                  bus_rvalid,
    input logic [3:0]            arb_id_o,
    input logic [64*NUM_ENT-1:0] redir_tbl_o,
    input logic [7:0]            sel_cur,
    input logic [3:0]            id_cur
);
    localparam logic [31:0] VER_WORD = {8'b0, 8'(NUM_ENT - 1), 8'b0, VERSION};
    localparam logic [8:0]  TBL_HI   = 9'h10 + 9'(2 * NUM_ENT);

    logic win_rd, win_wr, empty_idx;
    assign win_rd    = bus_rd && (bus_addr == BUS_AW'(1));
    assign win_wr    = bus_wr && (bus_addr == BUS_AW'(1));
    assign empty_idx = (sel_cur > 8'h01) && ((sel_cur < 8'h10) || ({1'b0, sel_cur} >= TBL_HI));

    a_r9_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == BUS_AW'(0)) |=> $stable(sel_cur));
    a_r5_arb_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && sel_cur == 8'h00) |=> (arb_id_o == $past(bus_wdata[27:24])));
    a_r5_arb_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && sel_cur == 8'h00) |=> ($stable(arb_id_o) && $stable(id_cur)));
    a_r4_version_value: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && sel_cur == 8'h01) |=> (bus_rdata == VER_WORD));
    a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && empty_idx) |=> (bus_rdata == 32'h0));
    a_r3_table_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(redir_tbl_o));

endmodule

bind irq_regwin irq_regwin_chk #(.BUS_AW(BUS_AW), .NUM_ENT(NUM_ENT), .VERSION(VERSION)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .arb_id_o    (arb_id_o),
    .redir_tbl_o (redir_tbl_o),
    .sel_cur     (sel_cur),
    .id_cur      (id_cur)
);

// File: tb/irq_regwin_tb_top.sv
// Directed bench for irq_regwin: one task per scenario.
module irq_regwin_tb_top;
    localparam int NE = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [3:0]        arb_id_o;
    logic [64*NE-1:0]  redir_tbl_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .arb_id_o(arb_id_o), .redir_tbl_o(redir_tbl_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Read with the valid flag checked; data is returned to the caller.
    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 valid after read", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        wr(2'd0, {24'b0, idx});
        rd(2'd1, d);
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] v);
        wr(2'd0, {24'b0, idx});
        wr(2'd1, v);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(2'd0, d);          chk("R2 index reset", 64'(d), 64'h0);
        chk("R7 arb id reset", 64'(arb_id_o), 64'h0);
        win_rd(8'h00, d);     chk("R7 id reset", 64'(d), 64'h0);
        win_rd(8'h10, d);     chk("R7 entry0 low masked", 64'(d), 64'h0001_0000);
        win_rd(8'h2F, d);     chk("R7 entry15 high zero", 64'(d), 64'h0);
        for (int i = 0; i < NE; i++)
            chk("R10 reset flat", redir_tbl_o[64*i +: 64], 64'h0000_0000_0001_0000);
    endtask

    task automatic t_index();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FF23);
        rd(2'd0, d);          chk("R2 index width", 64'(d), 64'h23);
    endtask

    task automatic t_version();
        logic [31:0] d;
        win_rd(8'h01, d);     chk("R4 version word", 64'(d), 64'h000F_0011);
        win_wr(8'h01, 32'hFFFF_FFFF);
        rd(2'd1, d);          chk("R4 version ignores write", 64'(d), 64'h000F_0011);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        win_wr(8'h00, 32'hFFFF_FFFF);
        chk("R5 arb id loads", 64'(arb_id_o), 64'hF);
        rd(2'd1, d);          chk("R5 id field only", 64'(d), 64'h0F00_0000);
        wr(2'd1, 32'h0500_0000);
        chk("R5 arb id reload", 64'(arb_id_o), 64'h5);
        rd(2'd1, d);          chk("R5 id reads back", 64'(d), 64'h0500_0000);
    endtask

    task automatic t_entries();
        logic [31:0] d;
        win_wr(8'h16, 32'hFFFF_FFFF);
        rd(2'd1, d);          chk("R6 low word fields", 64'(d), 64'h0001_8FFF);
        wr(2'd1, 32'h0000_0A42);
        rd(2'd1, d);          chk("R6 unmask entry3", 64'(d), 64'h0000_0A42);
        win_wr(8'h17, 32'hABCD_EF12);
        rd(2'd1, d);          chk("R6 high word dest", 64'(d), 64'hAB00_0000);
        chk("R10 entry3 flat", redir_tbl_o[64*3 +: 64], 64'hAB00_0000_0000_0A42);
        win_rd(8'h18, d);     chk("R3 entry4 untouched", 64'(d), 64'h0001_0000);
        win_rd(8'h14, d);     chk("R3 entry2 untouched", 64'(d), 64'h0001_0000);
        win_wr(8'h2F, 32'h3C00_0000);
        rd(2'd1, d);          chk("R6 last entry high", 64'(d), 64'h3C00_0000);
        chk("R10 entry15 flat", redir_tbl_o[64*15 +: 64], 64'h3C00_0000_0001_0000);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        win_wr(8'h30, 32'hFFFF_FFFF);
        rd(2'd1, d);          chk("R8 index 0x30 reads zero", 64'(d), 64'h0);
        win_wr(8'h0F, 32'hFFFF_FFFF);
        rd(2'd1, d);          chk("R8 index 0x0F reads zero", 64'(d), 64'h0);
        win_rd(8'h02, d);     chk("R8 index 0x02 reads zero", 64'(d), 64'h0);
        win_rd(8'h2E, d);     chk("R8 entry15 low intact", 64'(d), 64'h0001_0000);
        win_rd(8'h00, d);     chk("R8 id intact", 64'(d), 64'h0500_0000);
        chk("R8 arb id intact", 64'(arb_id_o), 64'h5);
    endtask

    task automatic t_bus_decode();
        logic [31:0] d;
        wr(2'd0, 32'h0000_0016);
        wr(2'd2, 32'h0000_0001);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, d);          chk("R1 unused address leaves index", 64'(d), 64'h16);
        rd(2'd1, d);          chk("R1 unused address leaves entry", 64'(d), 64'h0000_0A42);
        rd(2'd2, d);          chk("R1 unused address reads zero", 64'(d), 64'h0);
        rd(2'd3, d);          chk("R1 unused address 3 reads zero", 64'(d), 64'h0);
    endtask

    task automatic t_valid_timing();
        logic [31:0] d;
        rd(2'd0, d);
        @(negedge clk);
        chk("R9 valid one cycle only", 64'(bus_rvalid), 64'd0);
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        chk("R9 no valid in strobe cycle", 64'(bus_rvalid), 64'd0);
        @(negedge clk);
        chk("R9 back-to-back valid 1", 64'(bus_rvalid), 64'd1);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 back-to-back valid 2", 64'(bus_rvalid), 64'd1);
        @(negedge clk);
        chk("R9 valid drops", 64'(bus_rvalid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_index();
        t_version();
        t_ident();
        t_entries();
        t_unimpl();
        t_bus_decode();
        t_valid_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule